// File: doc/BRIEF.md
# Branch Resolution and Link Unit

This unit executes the branch step of a 32-bit core whose instructions are either 16 or 32 bits long. The decoder has already classified the branch and the condition logic has already evaluated it. For each request the unit takes the branch kind, whether the instruction is conditional, the condition-pass result, whether the instruction sits inside a predicated (IT) block, the current PC, the instruction length, a signed byte offset and a register operand.

One cycle later it returns a registered result: the redirect target and a taken flag, the link-register (R14) write value with its enable, and three fault flags. The fault flags cover a cleared state bit on an indirect target, a conditional/unconditional form placed where it is not allowed, and an offset beyond the reach of its form.

A request is accepted in every cycle in which the valid input is high, so results stream back-to-back with a latency of one cycle.

Top module: `branch_resolve`

## Requirements
- R1: Branch kind encoding on kind_i is 0 = direct, 1 = direct with link, 2 = register, 3 = register with link. A taken register form (2 or 3) redirects to rs_val_i with bit 0 cleared, and the range check does not apply to it.
- R2: A register form whose condition passes and whose rs_val_i bit 0 is 0 sets fault_state_o and does not redirect.
- R3: A taken linking form (1 or 3) sets lr_we_o and drives lr_data_o = (pc_i + 4) | 1 when len32_i = 1, or (pc_i + 2) | 1 when len32_i = 0. Forms 0 and 2 leave lr_we_o at 0.
- R4: A taken direct form (0 or 1) redirects to pc_i + 4 + offset_i with bit 0 cleared.
- R5: An unconditional direct branch, and the direct branch with link in any context, accept offsets from -2^24 to 2^24-1. Outside that range fault_range_o is set.
- R6: A conditional direct branch outside an IT block accepts offsets from -2^20 to 2^20-1. Inside an IT block it accepts -2^24 to 2^24-1. Outside the accepted range fault_range_o is set.
- R7: A conditional direct branch is legal anywhere. Every other combination must have is_cond_i equal to in_it_i, and fault_place_o is set when it does not.
- R8: With cond_pass_i = 0 the result has taken_o = 0, lr_we_o = 0 and fault_state_o = 0. Placement and range faults are still reported.
- R9: Any fault forces taken_o = 0, lr_we_o = 0, target_o = 0 and lr_data_o = 0.
- R10: req_ready_o is always 1. The result of a request with req_valid_i high appears with rsp_valid_o high in the next cycle. A cycle without a request gives rsp_valid_o = 0 with all flags and data at 0, which is also the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Always ready |
| kind_i | input | 2 | Branch kind |
| is_cond_i | input | 1 | Instruction is conditional |
| cond_pass_i | input | 1 | Condition evaluated true |
| in_it_i | input | 1 | Instruction lies inside an IT block |
| pc_i | input | ADDR_W | Address of the branch |
| len32_i | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| offset_i | input | ADDR_W | Signed byte offset of direct forms |
| rs_val_i | input | ADDR_W | Register operand of register forms |
| rsp_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Redirect requested |
| target_o | output | ADDR_W | Redirect address, 0 when not taken |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | ADDR_W | Link value, 0 when not written |
| fault_state_o | output | 1 | Indirect target has state bit 0 |
| fault_place_o | output | 1 | Illegal conditional placement |
| fault_range_o | output | 1 | Offset beyond reach of the form |

## Verification
Every result is due exactly one clock after its request. The target, link value, taken flag and the three fault flags all come from a single register stage. The bench drives a request on a falling edge, lets one rising edge capture it, and reads all outputs on the following falling edge. It then holds valid low for a cycle so that the idle state (R10) is also observed between requests.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
  typedef enum logic [1:0] {
    BK_DIR     = 2'd0,
    BK_DIR_LNK = 2'd1,
    BK_REG     = 2'd2,
    BK_REG_LNK = 2'd3
  } br_kind_e;

  function automatic logic kind_links(br_kind_e k);
    return k[0];
  endfunction

  function automatic logic kind_indirect(br_kind_e k);
    return k[1];
  endfunction
endpackage

// File: rtl/br_reach_check.sv
module br_reach_check #(
  parameter int OFF_W  = 32,
  parameter int NEAR_W = 21,
  parameter int FAR_W  = 25
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             near_ok_o,
  output logic             far_ok_o
);
  // offset fits if sign-extending its low bits reproduces it
  if (OFF_W > NEAR_W) begin : g_near
    logic [NEAR_W-1:0] low_n;
    assign low_n     = off_i[NEAR_W-1:0];
    assign near_ok_o = ({{(OFF_W-NEAR_W){low_n[NEAR_W-1]}}, low_n} == off_i);
  end else begin : g_near_all
    assign near_ok_o = 1'b1;
  end

  if (OFF_W > FAR_W) begin : g_far
    logic [FAR_W-1:0] low_f;
    assign low_f    = off_i[FAR_W-1:0];
    assign far_ok_o = ({{(OFF_W-FAR_W){low_f[FAR_W-1]}}, low_f} == off_i);
  end else begin : g_far_all
    assign far_ok_o = 1'b1;
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import branch_resolve_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  br_kind_e          kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              len32_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] link_o
);
  localparam logic [ADDR_W-1:0] BIT0 = ADDR_W'(1);

  logic [ADDR_W-1:0] dir_tgt, ind_tgt, step;

  assign dir_tgt  = (pc_i + ADDR_W'(4) + offset_i) & ~BIT0;
  assign ind_tgt  = rs_val_i & ~BIT0;
  assign target_o = kind_indirect(kind_i) ? ind_tgt : dir_tgt;
  assign step     = len32_i ? ADDR_W'(4) : ADDR_W'(2);
  assign link_o   = (pc_i + step) | BIT0;
endmodule

// File: rtl/br_fault_check.sv
module br_fault_check
  import branch_resolve_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     is_cond_i,
  input  logic     cond_pass_i,
  input  logic     in_it_i,
  input  logic     rs_bit0_i,
  input  logic     near_ok_i,
  input  logic     far_ok_i,
  output logic     f_state_o,
  output logic     f_place_o,
  output logic     f_range_o
);
  logic cond_direct, short_reach;

  assign cond_direct = (kind_i == BK_DIR) && is_cond_i;
  assign short_reach = cond_direct && !in_it_i;

  assign f_place_o = !cond_direct && (in_it_i != is_cond_i);
  assign f_range_o = !kind_indirect(kind_i) && (short_reach ? !near_ok_i : !far_ok_i);
  assign f_state_o = kind_indirect(kind_i) && cond_pass_i && !rs_bit0_i;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_resolve_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NEAR_W = 21,
  parameter int FAR_W  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        kind_i,
  input  logic              is_cond_i,
  input  logic              cond_pass_i,
  input  logic              in_it_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              len32_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic              rsp_valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_data_o,
  output logic              fault_state_o,
  output logic              fault_place_o,
  output logic              fault_range_o
);
  br_kind_e          kind;
  logic              near_ok, far_ok;
  logic              f_state, f_place, f_range, any_fault, tk, we;
  logic [ADDR_W-1:0] tgt, link;

  assign kind        = br_kind_e'(kind_i);
  assign req_ready_o = 1'b1;

  br_reach_check #(.OFF_W(ADDR_W), .NEAR_W(NEAR_W), .FAR_W(FAR_W)) u_reach (
    .off_i     (offset_i),
    .near_ok_o (near_ok),
    .far_ok_o  (far_ok)
  );

  br_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
    .kind_i   (kind),
    .pc_i     (pc_i),
    .len32_i  (len32_i),
    .offset_i (offset_i),
    .rs_val_i (rs_val_i),
    .target_o (tgt),
    .link_o   (link)
  );

  br_fault_check u_fault (
    .kind_i      (kind),
    .is_cond_i   (is_cond_i),
    .cond_pass_i (cond_pass_i),
    .in_it_i     (in_it_i),
    .rs_bit0_i   (rs_val_i[0]),
    .near_ok_i   (near_ok),
    .far_ok_i    (far_ok),
    .f_state_o   (f_state),
    .f_place_o   (f_place),
    .f_range_o   (f_range)
  );

  assign any_fault = f_state | f_place | f_range;
  assign tk        = cond_pass_i && !any_fault;
  assign we        = tk && kind_links(kind);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      taken_o       <= 1'b0;
      target_o      <= '0;
      lr_we_o       <= 1'b0;
      lr_data_o     <= '0;
      fault_state_o <= 1'b0;
      fault_place_o <= 1'b0;
      fault_range_o <= 1'b0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      taken_o       <= req_valid_i && tk;
      target_o      <= (req_valid_i && tk) ? tgt : '0;
      lr_we_o       <= req_valid_i && we;
      lr_data_o     <= (req_valid_i && we) ? link : '0;
      fault_state_o <= req_valid_i && f_state;
      fault_place_o <= req_valid_i && f_place;
      fault_range_o <= req_valid_i && f_range;
    end
  end

  assert_rsp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !taken_o && !lr_we_o && !fault_place_o));
  assert_fault_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_state_o || fault_place_o || fault_range_o) |-> (!taken_o && !lr_we_o && target_o == '0));
  assert_link_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> (taken_o && lr_data_o[0]));
  assert_target_even_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> !target_o[0]);
  assert_no_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cond_pass_i) |=> (!taken_o && !lr_we_o && !fault_state_o));
  assert_state_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cond_pass_i && kind_i[1] && !rs_val_i[0]) |=> fault_state_o);
endmodule

// File: tb/branch_resolve_tb.sv
`timescale 1ns/1ps
module branch_resolve_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  kind = '0;
  logic        is_cond = 1'b0, cond_pass = 1'b0, in_it = 1'b0, len32 = 1'b0;
  logic [31:0] pc = '0, offset = '0, rs_val = '0;
  logic        rsp_valid, taken, lr_we, f_state, f_place, f_range;
  logic [31:0] target, lr_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  branch_resolve u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .kind_i(kind), .is_cond_i(is_cond), .cond_pass_i(cond_pass), .in_it_i(in_it),
    .pc_i(pc), .len32_i(len32), .offset_i(offset), .rs_val_i(rs_val),
    .rsp_valid_o(rsp_valid), .taken_o(taken), .target_o(target),
    .lr_we_o(lr_we), .lr_data_o(lr_data), .fault_state_o(f_state),
    .fault_place_o(f_place), .fault_range_o(f_range)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "rsp_valid", 32'(rsp_valid), 0);
    chk(tag, "taken", 32'(taken), 0);
    chk(tag, "lr_we", 32'(lr_we), 0);
    chk(tag, "target", target, 0);
    chk(tag, "faults", {29'd0, f_state, f_place, f_range}, 0);
    chk(tag, "ready", 32'(req_ready), 1);
  endtask

  task automatic run(input logic [1:0] k, input logic c, input logic p, input logic it,
                     input logic [31:0] a, input logic l32, input logic [31:0] off, input logic [31:0] rs);
    logic ind, lnk, pe, re, se, tk, we;
    logic [31:0] e_tgt, e_lr;
    longint so, lim;
    @(negedge clk);
    kind = k; is_cond = c; cond_pass = p; in_it = it; pc = a; len32 = l32;
    offset = off; rs_val = rs; req_valid = 1'b1;
    ind = k[1]; lnk = k[0];
    pe  = !(k == 2'd0 && c) && (it != c);
    lim = (k == 2'd0 && c && !it) ? 64'sd1048576 : 64'sd16777216;
    so  = longint'($signed(off));
    re  = !ind && (so < -lim || so >= lim);
    se  = ind && p && !rs[0];
    tk  = p && !(pe || re || se);
    we  = tk && lnk;
    e_tgt = tk ? (ind ? (rs & ~32'd1) : ((a + 32'd4 + off) & ~32'd1)) : 32'd0;
    e_lr  = we ? ((a + (l32 ? 32'd4 : 32'd2)) | 32'd1) : 32'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "rsp_valid", 32'(rsp_valid), 1);
    chk(p ? "R9" : "R8", "taken", 32'(taken), 32'(tk));
    chk(ind ? "R1" : "R4", "target", target, e_tgt);
    chk("R3", "lr_we", 32'(lr_we), 32'(we));
    chk("R3", "lr_data", lr_data, e_lr);
    chk("R2", "fault_state", 32'(f_state), 32'(se));
    chk("R7", "fault_place", 32'(f_place), 32'(pe));
    chk((k == 2'd0 && c && !it) ? "R6" : "R5", "fault_range", 32'(f_range), 32'(re));
    @(negedge clk);
    chk_idle("R10");
  endtask

  function automatic logic [31:0] pick_off();
    logic [31:0] d;
    d = ($urandom % 8) * 2;
    case ($urandom % 5)
      0: return ($urandom % 4096) & ~32'd1;
      1: return 32'h0010_0000 - 32'd8 + d;
      2: return 32'hFFF0_0000 - 32'd8 + d;
      3: return ($urandom % 2) ? (32'h0100_0000 - 32'd8 + d) : (32'hFF00_0000 - 32'd8 + d);
      default: return $urandom & ~32'd1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk_idle("R10");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10");

    // R1 / R2: indirect targets and state bit
    run(2'd2, 0, 1, 0, 32'h1000, 1, 0, 32'h8000_1235);
    run(2'd3, 0, 1, 0, 32'h1000, 0, 0, 32'h0000_4001);
    run(2'd2, 0, 1, 0, 32'h1000, 1, 0, 32'h0000_4000);
    run(2'd3, 1, 0, 1, 32'h1000, 1, 0, 32'h0000_4000);  // R8 no state fault
    // R3 / R4: direct, link with both lengths
    run(2'd1, 0, 1, 0, 32'h2000_0100, 1, 32'hFFFF_FF00, 0);
    run(2'd1, 0, 1, 0, 32'h2000_0102, 0, 32'h0000_0040, 0);
    run(2'd0, 0, 1, 0, 32'h0000_0010, 0, 32'h0000_0020, 0);
    // R5 boundaries
    run(2'd0, 0, 1, 0, 32'h100, 1, 32'h00FF_FFFE, 0);
    run(2'd0, 0, 1, 0, 32'h100, 1, 32'h0100_0000, 0);
    run(2'd1, 0, 1, 0, 32'h100, 1, 32'hFF00_0000, 0);
    run(2'd1, 0, 1, 0, 32'h100, 1, 32'hFEFF_FFFE, 0);
    // R6 conditional direct reach
    run(2'd0, 1, 1, 0, 32'h100, 0, 32'h000F_FFFE, 0);
    run(2'd0, 1, 1, 0, 32'h100, 0, 32'h0010_0000, 0);
    run(2'd0, 1, 1, 0, 32'h100, 0, 32'hFFF0_0000, 0);
    run(2'd0, 1, 1, 0, 32'h100, 0, 32'hFFEF_FFFE, 0);
    run(2'd0, 1, 1, 1, 32'h100, 0, 32'h0010_0000, 0);
    // R7 placement
    run(2'd0, 0, 1, 1, 32'h100, 0, 32'h10, 0);
    run(2'd1, 1, 1, 0, 32'h100, 1, 32'h10, 0);
    run(2'd2, 0, 1, 1, 32'h100, 0, 0, 32'h301);
    run(2'd3, 1, 1, 1, 32'h100, 0, 0, 32'h301);
    run(2'd1, 1, 0, 0, 32'h100, 1, 32'h10, 0);  // R8 placement still reported

    for (int i = 0; i < 400; i++)
      run(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
          $urandom, 1'($urandom % 2), pick_off(), $urandom);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule